// File: doc/BRIEF.md
# Quadrature Mixer with Mid-Scale Bias Removal

This block sits at the head of a digital down-converter. Unsigned codes come in from a 10-bit converter whose analog input was lifted to half of its reference. The block turns each code into a signed value by taking off the mid-scale constant. It then multiplies that value by a cosine and a sine from an on-chip numerically controlled oscillator, which gives an in-phase and a quadrature product. The filters that follow decimate these two product streams.

The oscillator and the sample path run on the same clock, nominally 20 MHz, with one sample per clock. A 24-bit tuning word sets the mixing frequency to `tune_word_i * f_clk / 2^24`. A wave table covers one quarter of a period. Mirror and negate logic builds the other three quadrants from it, for both the sine and the cosine.

Top module: `iq_mixer`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first valid sample reaches the output, `valid_o` is 0 and `i_o` and `q_o` are 0. Reset also sets the phase accumulator to 0.
- R2: Each input code c becomes the signed value s = c - 512, taking it off the mid-scale constant 2^(SMP_W-1). Code 512 therefore gives 0 on both products, code 0 gives s = -512, and code 1023 gives s = 511.
- R3: `i_o` = s * cos and `q_o` = s * sin. Both are kept at full precision as 22-bit two's-complement values, with no rounding and no truncation.
- R4: `valid_o` equals `valid_i` delayed by exactly two clocks. The products on that cycle belong to the sample that was presented two clocks earlier.
- R5: On every clock edge after reset, the 24-bit phase accumulator adds `tune_word_i` and wraps modulo 2^24. A sample is mixed using the phase value held in the accumulator just before the edge that captures it.
- R6: Let p be bits [23:16] of that phase. Bits [23:22] are the quadrant. The oscillator gives sin = round(2047 * sin(2*pi*(p+0.5)/256)) and cos = round(2047 * cos(2*pi*(p+0.5)/256)), each a 12-bit signed value. Rounding is half away from zero. Neither value is ever 0. The sign of sin is negative exactly when bit 23 is set.
- R7: A change of `tune_word_i` alters only the step size of the accumulator from the next edge on. The accumulated phase is never cleared, so the phase stays continuous across the change.
- R8: While `valid_i` is low, `i_o` and `q_o` keep their last values. The accumulator still advances on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tune_word_i | input | 24 | Phase increment per clock |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | 10 | Unsigned converter code, biased at mid-scale |
| valid_o | output | 1 | Product strobe, two clocks after `valid_i` |
| i_o | output | 22 | In-phase product, signed |
| q_o | output | 22 | Quadrature product, signed |

## Verification
The assertions assume that `valid_i` and `tune_word_i` are held at 0 while reset is applied. They also assume that `sample_i` and `tune_word_i` change only away from the active edge. The bench drives every input on the falling edge and holds the strobe low until after reset is released.

It takes one tuning step per table entry to walk the phase through all 256 table positions at both code extremes. It applies all 1024 codes under an irregular tuning word. It changes the tuning word in the middle of a stream and inserts gaps in the strobe, so that the phase is seen advancing while the products hold.

// File: rtl/iq_mix_pkg.sv
package iq_mix_pkg;
  localparam real PI = 3.14159265358979323846;

  // round half away from zero
  function automatic int round_haz(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction
endpackage

// File: rtl/iq_phase_acc.sv
module iq_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      armed_q <= 1'b0;
    end else begin
      phase_o <= phase_o + step_i;
      armed_q <= 1'b1;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (phase_o == $past(phase_o) + $past(step_i))) else $error("phase step"); // R5
endmodule

// File: rtl/iq_quarter_lut.sv
module iq_quarter_lut #(
  parameter int PHASE_W = 24,
  parameter int LUT_AW  = 6,
  parameter int AMP_W   = 12
) (
  input  logic [PHASE_W-1:0]      phase_i,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);
  import iq_mix_pkg::*;

  localparam int DEPTH = 1 << LUT_AW;
  localparam int MAG_W = AMP_W - 1;

  function automatic logic [MAG_W-1:0] tbl_val(int k);
    real a;
    int  v;
    a = (2.0 ** (AMP_W - 1) - 1.0) * $sin(PI * (2.0 * k + 1.0) / (4.0 * DEPTH));
    v = round_haz(a);
    return v[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    assign tbl[k] = tbl_val(k);
  end

  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx, idx_m;
  logic [MAG_W-1:0]  sin_mag, cos_mag;
  logic              sin_neg, cos_neg;

  assign quad  = phase_i[PHASE_W-1 -: 2];
  assign idx   = phase_i[PHASE_W-3 -: LUT_AW];
  assign idx_m = ~idx;

  always_comb begin
    sin_mag = quad[0] ? tbl[idx_m] : tbl[idx];
    cos_mag = quad[0] ? tbl[idx] : tbl[idx_m];
    sin_neg = quad[1];
    cos_neg = quad[1] ^ quad[0];
    sin_o = sin_neg ? -$signed({1'b0, sin_mag}) : $signed({1'b0, sin_mag});
    cos_o = cos_neg ? -$signed({1'b0, cos_mag}) : $signed({1'b0, cos_mag});
  end
endmodule

// File: rtl/iq_mult_stage.sv
module iq_mult_stage #(
  parameter int SMP_W = 10,
  parameter int AMP_W = 12,
  localparam int PRD_W = SMP_W + AMP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [AMP_W-1:0] sin_i,
  input  logic signed [AMP_W-1:0] cos_i,
  output logic                    valid_o,
  output logic signed [PRD_W-1:0] i_o,
  output logic signed [PRD_W-1:0] q_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
      armed_q <= 1'b0;
    end else begin
      valid_o <= valid_i;
      armed_q <= 1'b1;
      if (valid_i) begin
        i_o <= smp_i * cos_i;
        q_o <= smp_i * sin_i;
      end
    end
  end

  AST_ZERO_AT_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && smp_i == '0) |=> (i_o == '0 && q_o == '0)) else $error("mid"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(valid_i)) |-> ($stable(i_o) && $stable(q_o))) else $error("hold"); // R8
endmodule

// File: rtl/iq_mixer.sv
module iq_mixer #(
  parameter int SMP_W   = 10,
  parameter int PHASE_W = 24,
  parameter int LUT_AW  = 6,
  parameter int AMP_W   = 12,
  localparam int PRD_W  = SMP_W + AMP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] tune_word_i,
  input  logic               valid_i,
  input  logic [SMP_W-1:0]   sample_i,
  output logic               valid_o,
  output logic [PRD_W-1:0]   i_o,
  output logic [PRD_W-1:0]   q_o
);
  localparam logic [SMP_W:0] MID = (SMP_W+1)'(1 << (SMP_W - 1));

  logic [PHASE_W-1:0]      phase;
  logic signed [AMP_W-1:0] sin_w, cos_w;
  logic [SMP_W:0]          diff;
  logic                    v1_q;
  logic signed [SMP_W-1:0] s1_q;
  logic signed [AMP_W-1:0] sin1_q, cos1_q;
  logic signed [PRD_W-1:0] i_w, q_w;
  logic [1:0]              age_q;

  iq_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(tune_word_i), .phase_o(phase)
  );

  iq_quarter_lut #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_lut (
    .phase_i(phase), .sin_o(sin_w), .cos_o(cos_w)
  );

  // bias removal: range of code - mid fits SMP_W signed bits
  assign diff = {1'b0, sample_i} - MID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      s1_q   <= '0;
      sin1_q <= '0;
      cos1_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        s1_q   <= $signed(diff[SMP_W-1:0]);
        sin1_q <= sin_w;
        cos1_q <= cos_w;
      end
    end
  end

  iq_mult_stage #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(v1_q), .smp_i(s1_q),
    .sin_i(sin1_q), .cos_i(cos1_q), .valid_o(valid_o), .i_o(i_w), .q_o(q_w)
  );

  assign i_o = i_w;
  assign q_o = q_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (valid_o == $past(valid_i, 2))) else $error("latency"); // R4
  AST_OSC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_w != '0) && (cos_w != '0)) else $error("osc zero"); // R6
  AST_SIN_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_w < 0) == phase[PHASE_W-1]) else $error("sin sign"); // R6
endmodule

// File: tb/iq_mixer_tb_top.sv
module iq_mixer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] tw = '0;
  logic        vin = 1'b0;
  logic [9:0]  smp = '0;
  logic        vout;
  logic [21:0] iout, qout;

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit done = 0;
  logic [23:0] mphase = '0;
  logic        ev [4];
  int          ei [4];
  int          eq [4];
  string       etag [4];
  int          last_i = 0, last_q = 0;

  always #2 clk = ~clk;

  iq_mixer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tune_word_i(tw), .valid_i(vin),
    .sample_i(smp), .valid_o(vout), .i_o(iout), .q_o(qout)
  );

  function automatic int rnd(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at step %0d", tag, act, exp, n);
    end
  endtask

  // at negedge n: check outcome of drive n-2, then drive step n
  task automatic step(bit v, int code, logic [23:0] word, string tag);
    int p, s, sv, cv;
    @(negedge clk);
    if (n >= 2) begin
      int k = (n - 2) % 4;
      chk({"R4 valid ", etag[k]}, int'(vout), int'(ev[k]));
      if (ev[k]) begin
        last_i = ei[k];
        last_q = eq[k];
        chk({"R3 I ", etag[k]}, $signed(iout), ei[k]);
        chk({"R3 Q ", etag[k]}, $signed(qout), eq[k]);
      end else begin
        chk({"R8 hold I ", etag[k]}, $signed(iout), last_i);
        chk({"R8 hold Q ", etag[k]}, $signed(qout), last_q);
      end
    end
    p  = int'(mphase[23:16]);
    s  = code - 512;
    sv = rnd(2047.0 * $sin(2.0 * 3.14159265358979323846 * (p + 0.5) / 256.0));
    cv = rnd(2047.0 * $cos(2.0 * 3.14159265358979323846 * (p + 0.5) / 256.0));
    ev[n % 4]   = v;
    ei[n % 4]   = s * cv;
    eq[n % 4]   = s * sv;
    etag[n % 4] = tag;
    vin = v;
    smp = code[9:0];
    tw  = word;
    mphase = mphase + word;
    n++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1 valid in reset", int'(vout), 0);
    chk("R1 I in reset", int'(iout), 0);
    chk("R1 Q in reset", int'(qout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", int'(vout), 0);
    chk("R1 I after release", int'(iout), 0);

    // R6 R5: walk all 256 table positions at both code extremes
    for (int i = 0; i < 256; i++) step(1'b1, 1023, 24'h010000, "R6 sweep max");
    for (int i = 0; i < 256; i++) step(1'b1, 0, 24'h010000, "R6 sweep min");
    // R2: mid code yields zero products
    for (int i = 0; i < 16; i++) step(1'b1, 512, 24'h0A3000, "R2 mid");
    // R2 R3: every code under an irregular tuning word
    for (int c = 0; c < 1024; c++) step(1'b1, c, 24'h12345B, "R2 R3 all codes");
    // R7: tuning changes mid-stream, phase continues
    for (int i = 0; i < 40; i++) step(1'b1, 100 + i, 24'h004321, "R7 before");
    for (int i = 0; i < 40; i++) step(1'b1, 900 - i, 24'hF81234, "R7 after");
    for (int i = 0; i < 40; i++) step(1'b1, 333 + i, 24'h7FFFFF, "R7 again");
    // R8: gaps in strobe, phase keeps advancing
    for (int i = 0; i < 120; i++)
      step((i % 3) == 0, (i * 37) % 1024, 24'h033333, "R8 gaps");
    for (int i = 0; i < 8; i++) step(1'b0, 777, 24'h055555, "R8 idle");
    step(1'b1, 1000, 24'h000001, "R5 after idle");
    step(1'b0, 0, 24'h0, "R4 flush");
    step(1'b0, 0, 24'h0, "R4 flush");
    step(1'b0, 0, 24'h0, "R4 flush");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule